// File: doc/BRIEF.md
# Dead-Time Complementary PWM Generator

This block drives a pulse-width-modulated output from the chip clock. Every clock cycle counts as one tick. Software-side logic supplies an active-phase tick count and a rest-phase tick count as plain integers. Each setting goes into a single pending slot, and the generator moves that slot into its working registers at a safe moment. It then emits an active phase of the active count followed by a rest phase of the rest count, and repeats the pair until a new setting arrives.

A second output can be enabled for bridge-style loads. In that case a programmable dead gap separates the two outputs at both handovers, and the gap is taken out of each output's own phase. An optional fast-reload mode can cut the running period short to apply a new setting at once. A guard can limit that cut to moments when the main output is low. A pause input with a clearing option holds both outputs low and rewinds the period.

Top module: `pwm_deadband_gen`

## Requirements
- R1: Every stored active and rest count is at least 2 ticks. A requested value of 0 or 1 becomes 2 on its own, whatever the other count is.
- R2: The fastest setting, 2 active and 2 rest, gives a 4-tick period with the main output high for the first 2 ticks.
- R3: Without fast reload, a setting written while a period runs is held until that period's last rest tick. The new period begins on the next edge.
- R4: The pending slot holds one setting. A second write before the slot is taken replaces the first, and the first is never applied.
- R5: `ack` is high for exactly one cycle: the cycle that starts at the edge where the slot is loaded into the working registers. It is low in every other cycle.
- R6: With `pair_en` = 1 and an effective dead gap D, the main output is high for the first (active count − D) ticks of the active phase. The complement is high for the first (rest count − D) ticks of the rest phase. The two outputs are never high together.
- R7: The effective dead gap is `dead_ticks`, raised to 2 when it is smaller. The gap is applied in full even when it is as long as a phase, and such a phase then stays low for its whole length.
- R8: With `fast_reload` = 1, a pending setting loads on the next edge and restarts the period. If `low_only_reload` is also 1, the load waits for a cycle in which the main output is low.
- R9: While `pause` and `pause_clears` are both 1, both outputs are low, no setting is loaded, and the period rewinds to the first active tick. It resumes from that tick when pause drops. `pause` with `pause_clears` = 0 has no effect.
- R10: After reset both outputs and `ack` are low and nothing runs until a write arrives. A write sampled on edge k is loaded on edge k+1 when idle, and the main output rises in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe for a new setting |
| wr_high_ticks | input | CNT_W | Requested active-phase count |
| wr_low_ticks | input | CNT_W | Requested rest-phase count |
| pair_en | input | 1 | Enables the complementary output and the dead gap |
| dead_ticks | input | DT_W | Requested dead gap in ticks |
| fast_reload | input | 1 | Load a pending setting without waiting for the period end |
| low_only_reload | input | 1 | Restrict fast reload to cycles with the main output low |
| pause | input | 1 | Pause request |
| pause_clears | input | 1 | Pause rewinds the counters and blanks the outputs |
| pwm_main | output | 1 | Main PWM output |
| pwm_comp | output | 1 | Complementary PWM output |
| ack | output | 1 | One-cycle pulse on each load of a pending setting |

## Verification
A write takes two edges to show at an idle output: one edge captures it into the slot, and the next edge loads it. While the generator is running, a normal write stays pending until the rest phase ends. A fast-reload write loads one edge after capture, or at the first low-main cycle when the guard is on. The bench drives inputs just after a rising edge and pushes, for that same cycle, the outputs the requirements predict. The monitor compares at the following falling edge, so each expectation carries the exact edge count for that case: pause gating and `pair_en` act in the same cycle, and loads and `ack` act one or two edges later.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
   typedef enum logic {
      PH_ACT  = 1'b0,
      PH_REST = 1'b1
   } pwm_phase_t;
endpackage

// File: rtl/pwm_dt_slot.sv
module pwm_dt_slot #(
   parameter int CNT_W     = 32,
   parameter int MIN_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [CNT_W-1:0] wr_high,
   input  logic [CNT_W-1:0] wr_low,
   input  logic             take,
   output logic             slot_valid,
   output logic [CNT_W-1:0] slot_high,
   output logic [CNT_W-1:0] slot_low
);
   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TICKS);

   logic [CNT_W-1:0] high_fl, low_fl;

   always_comb begin
      high_fl = (wr_high < FLOOR) ? FLOOR : wr_high;
      low_fl  = (wr_low  < FLOOR) ? FLOOR : wr_low;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_valid <= 1'b0;
         slot_high  <= FLOOR;
         slot_low   <= FLOOR;
      end else if (wr_valid) begin
         slot_valid <= 1'b1;
         slot_high  <= high_fl;
         slot_low   <= low_fl;
      end else if (take) begin
         slot_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_dt_core.sv
module pwm_dt_core
   import pwm_dt_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int MIN_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             slot_valid,
   input  logic [CNT_W-1:0] slot_high,
   input  logic [CNT_W-1:0] slot_low,
   input  logic             fast_reload,
   input  logic             low_only,
   input  logic             main_now,
   output logic             take,
   output logic             running,
   output pwm_phase_t       phase,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act_high,
   output logic [CNT_W-1:0] act_low,
   output logic             period_end,
   output logic             ack
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TICKS);

   logic early_ok;

   always_comb begin
      period_end = running && (phase == PH_REST) && (cnt == '0);
      early_ok   = fast_reload && (!low_only || !main_now);
      take       = slot_valid && !hold && (!running || period_end || early_ok);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         phase    <= PH_ACT;
         cnt      <= '0;
         act_high <= FLOOR;
         act_low  <= FLOOR;
         ack      <= 1'b0;
      end else begin
         ack <= take;
         if (hold) begin
            if (running) begin
               phase <= PH_ACT;
               cnt   <= act_high - ONE;
            end
         end else if (take) begin
            act_high <= slot_high;
            act_low  <= slot_low;
            phase    <= PH_ACT;
            cnt      <= slot_high - ONE;
            running  <= 1'b1;
         end else if (running) begin
            if (cnt == '0) begin
               if (phase == PH_ACT) begin
                  phase <= PH_REST;
                  cnt   <= act_low - ONE;
               end else begin
                  phase <= PH_ACT;
                  cnt   <= act_high - ONE;
               end
            end else begin
               cnt <= cnt - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/pwm_dt_shaper.sv
module pwm_dt_shaper
   import pwm_dt_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int DT_W         = 16,
   parameter int MIN_TICKS    = 2,
   parameter bit COMP_SUPPORT = 1'b1
) (
   input  logic             running,
   input  logic             hold,
   input  pwm_phase_t       phase,
   input  logic [CNT_W-1:0] cnt,
   input  logic             pair_en,
   input  logic [DT_W-1:0]  dead_ticks,
   output logic             main_o,
   output logic             comp_o
);
   localparam int             PAD      = CNT_W - DT_W;
   localparam logic [DT_W-1:0] DT_FLOOR = DT_W'(MIN_TICKS);

   logic live;
   assign live = running && !hold;

   generate
      if (COMP_SUPPORT) begin : g_pair
         logic [DT_W-1:0]  dead_fl;
         logic [CNT_W-1:0] dead_ext;
         always_comb begin
            dead_fl  = (dead_ticks < DT_FLOOR) ? DT_FLOOR : dead_ticks;
            dead_ext = {{PAD{1'b0}}, dead_fl};
            if (pair_en) begin
               main_o = live && (phase == PH_ACT)  && (cnt >= dead_ext);
               comp_o = live && (phase == PH_REST) && (cnt >= dead_ext);
            end else begin
               main_o = live && (phase == PH_ACT);
               comp_o = 1'b0;
            end
         end
      end else begin : g_single
         logic unused_cfg;
         assign unused_cfg = pair_en ^ (^dead_ticks) ^ (^cnt);
         assign main_o     = live && (phase == PH_ACT);
         assign comp_o     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwm_deadband_gen.sv
module pwm_deadband_gen
   import pwm_dt_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int DT_W         = 16,
   parameter int MIN_TICKS    = 2,
   parameter bit COMP_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [CNT_W-1:0] wr_high_ticks,
   input  logic [CNT_W-1:0] wr_low_ticks,
   input  logic             pair_en,
   input  logic [DT_W-1:0]  dead_ticks,
   input  logic             fast_reload,
   input  logic             low_only_reload,
   input  logic             pause,
   input  logic             pause_clears,
   output logic             pwm_main,
   output logic             pwm_comp,
   output logic             ack
);
   generate
      if (CNT_W <= DT_W) begin : g_bad_widths
         $error("CNT_W must be wider than DT_W");
      end
      if (MIN_TICKS < 1) begin : g_bad_floor
         $error("MIN_TICKS must be at least 1");
      end
   endgenerate

   logic             hold;
   logic             take;
   logic             slot_valid;
   logic [CNT_W-1:0] slot_high, slot_low;
   logic             running;
   pwm_phase_t       phase;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_high, act_low;
   logic             period_end;

   assign hold = pause && pause_clears;

   pwm_dt_slot #(.CNT_W(CNT_W), .MIN_TICKS(MIN_TICKS)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .wr_high    (wr_high_ticks),
      .wr_low     (wr_low_ticks),
      .take       (take),
      .slot_valid (slot_valid),
      .slot_high  (slot_high),
      .slot_low   (slot_low)
   );

   pwm_dt_core #(.CNT_W(CNT_W), .MIN_TICKS(MIN_TICKS)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold        (hold),
      .slot_valid  (slot_valid),
      .slot_high   (slot_high),
      .slot_low    (slot_low),
      .fast_reload (fast_reload),
      .low_only    (low_only_reload),
      .main_now    (pwm_main),
      .take        (take),
      .running     (running),
      .phase       (phase),
      .cnt         (cnt),
      .act_high    (act_high),
      .act_low     (act_low),
      .period_end  (period_end),
      .ack         (ack)
   );

   pwm_dt_shaper #(
      .CNT_W(CNT_W), .DT_W(DT_W), .MIN_TICKS(MIN_TICKS), .COMP_SUPPORT(COMP_SUPPORT)
   ) u_shape (
      .running    (running),
      .hold       (hold),
      .phase      (phase),
      .cnt        (cnt),
      .pair_en    (pair_en),
      .dead_ticks (dead_ticks),
      .main_o     (pwm_main),
      .comp_o     (pwm_comp)
   );
endmodule

// File: rtl/pwm_deadband_gen_chk.sv
module pwm_deadband_gen_chk #(
   parameter int CNT_W     = 32,
   parameter int MIN_TICKS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwm_main,
   input logic             pwm_comp,
   input logic             ack,
   input logic             fast_reload,
   input logic             low_only_reload,
   input logic             pause,
   input logic             pause_clears,
   input logic             running,
   input logic             slot_valid,
   input logic             period_end,
   input logic [CNT_W-1:0] act_high,
   input logic [CNT_W-1:0] act_low
);
   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TICKS);

   // R1
   count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (act_high >= FLOOR) && (act_low >= FLOOR));

   // R5
   ack_from_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(slot_valid));

   // R6
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_main && pwm_comp));

   // R3
   end_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !$past(fast_reload)) |-> ($past(period_end) || !$past(running)));

   // R8
   low_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(fast_reload && low_only_reload && running)) |-> !$past(pwm_main));

   // R9
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause && pause_clears) |-> (!pwm_main && !pwm_comp));

   // R9
   hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pause && pause_clears) |-> !ack);

   // R10
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!pwm_main && !pwm_comp));
endmodule

bind pwm_deadband_gen pwm_deadband_gen_chk #(.CNT_W(CNT_W), .MIN_TICKS(MIN_TICKS)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .pwm_main        (pwm_main),
   .pwm_comp        (pwm_comp),
   .ack             (ack),
   .fast_reload     (fast_reload),
   .low_only_reload (low_only_reload),
   .pause           (pause),
   .pause_clears    (pause_clears),
   .running         (running),
   .slot_valid      (slot_valid),
   .period_end      (period_end),
   .act_high        (act_high),
   .act_low         (act_low)
);

// File: tb/pwm_deadband_gen_test.sv
module pwm_deadband_gen_test;
   localparam int CLK_P = 10;
   localparam int CW    = 32;
   localparam int DW    = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_valid;
   logic [CW-1:0] wr_high_ticks, wr_low_ticks;
   logic          pair_en;
   logic [DW-1:0] dead_ticks;
   logic          fast_reload, low_only_reload, pause, pause_clears;
   logic          pwm_main, pwm_comp, ack;

   typedef struct {
      bit    m;
      bit    c;
      bit    a;
      string tag;
   } exp_t;

   exp_t sb_q[$];
   exp_t mon_e;
   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pwm_deadband_gen #(.CNT_W(CW), .DT_W(DW)) uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_valid        (wr_valid),
      .wr_high_ticks   (wr_high_ticks),
      .wr_low_ticks    (wr_low_ticks),
      .pair_en         (pair_en),
      .dead_ticks      (dead_ticks),
      .fast_reload     (fast_reload),
      .low_only_reload (low_only_reload),
      .pause           (pause),
      .pause_clears    (pause_clears),
      .pwm_main        (pwm_main),
      .pwm_comp        (pwm_comp),
      .ack             (ack)
   );

   // monitor: one expected item per cycle, compared at the falling edge
   always @(negedge clk) begin
      if (sb_q.size() != 0) begin
         mon_e = sb_q.pop_front();
         vectors++;
         if ({pwm_main, pwm_comp, ack} !== {mon_e.m, mon_e.c, mon_e.a}) begin
            miscompares++;
            $display("FAIL %s: main/comp/ack = %b%b%b, expected %b%b%b at %0t",
                     mon_e.tag, pwm_main, pwm_comp, ack, mon_e.m, mon_e.c, mon_e.a, $time);
         end
      end
   end

   task automatic edge_wait();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input bit m, input bit c, input bit a, input string tag);
      exp_t e;
      e.m = m; e.c = c; e.a = a; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic put(input int h, input int l);
      wr_valid      = 1'b1;
      wr_high_ticks = CW'(h);
      wr_low_ticks  = CW'(l);
   endtask

   // one full period starting at its first active tick; d is the effective dead gap
   task automatic run_period(input int h, input int l, input int d, input bit comp,
                             input bit first_ack, input string tag);
      for (int i = 0; i < h; i++) begin
         edge_wait();
         expect_out(comp ? (h - 1 - i >= d) : 1'b1, 1'b0, first_ack && (i == 0), tag);
      end
      for (int j = 0; j < l; j++) begin
         edge_wait();
         expect_out(1'b0, comp ? (l - 1 - j >= d) : 1'b0, 1'b0, tag);
      end
   endtask

   initial begin
      rst_n = 1'b0; wr_valid = 1'b0; wr_high_ticks = '0; wr_low_ticks = '0;
      pair_en = 1'b0; dead_ticks = '0; fast_reload = 1'b0; low_only_reload = 1'b0;
      pause = 1'b0; pause_clears = 1'b0;

      // R10: quiet in reset and idle until a write
      repeat (3) begin edge_wait(); expect_out(0, 0, 0, "R10 reset"); end
      edge_wait(); rst_n = 1'b1; expect_out(0, 0, 0, "R10 reset");
      repeat (3) begin edge_wait(); expect_out(0, 0, 0, "R10 idle"); end

      // R1/R2: 1 and 0 raised to 2 and 2, 4-tick period
      edge_wait(); put(1, 0); expect_out(0, 0, 0, "R10 capture");
      edge_wait(); wr_valid = 1'b0; expect_out(0, 0, 0, "R10 capture");
      run_period(2, 2, 0, 1'b0, 1'b1, "R2");
      run_period(2, 2, 0, 1'b0, 1'b0, "R1");
      run_period(2, 2, 0, 1'b0, 1'b0, "R5");

      // R3: mid-period write waits for the period end; 1 raised to 2
      edge_wait(); put(3, 1); expect_out(1, 0, 0, "R3");
      edge_wait(); wr_valid = 1'b0; expect_out(1, 0, 0, "R3");
      edge_wait(); expect_out(0, 0, 0, "R3");
      edge_wait(); expect_out(0, 0, 0, "R3");
      run_period(3, 2, 0, 1'b0, 1'b1, "R3");

      // R4: second write replaces the first
      edge_wait(); put(9, 9); expect_out(1, 0, 0, "R4");
      edge_wait(); put(4, 3); expect_out(1, 0, 0, "R4");
      edge_wait(); wr_valid = 1'b0; expect_out(1, 0, 0, "R4");
      edge_wait(); expect_out(0, 0, 0, "R4");
      edge_wait(); expect_out(0, 0, 0, "R4");
      run_period(4, 3, 0, 1'b0, 1'b1, "R4");

      // R9: clearing pause blanks, blocks loads, rewinds; R6/R7 dead gap 1 -> 2
      edge_wait(); pause = 1'b1; pause_clears = 1'b1; expect_out(0, 0, 0, "R9");
      edge_wait(); put(6, 4); pair_en = 1'b1; dead_ticks = DW'(1); expect_out(0, 0, 0, "R9");
      edge_wait(); wr_valid = 1'b0; expect_out(0, 0, 0, "R9");
      edge_wait(); pause = 1'b0; expect_out(1, 0, 0, "R9 resume");
      edge_wait(); expect_out(1, 0, 0, "R7");
      edge_wait(); expect_out(0, 0, 0, "R7");
      edge_wait(); expect_out(0, 0, 0, "R7");
      edge_wait(); expect_out(0, 1, 0, "R6");
      edge_wait(); expect_out(0, 0, 0, "R6");
      edge_wait(); expect_out(0, 0, 0, "R6");
      run_period(6, 4, 2, 1'b1, 1'b1, "R6");
      run_period(6, 4, 2, 1'b1, 1'b0, "R6");

      // R8 with guard: load waits for main low; R9 pause without clearing is ignored
      edge_wait(); pair_en = 1'b0; fast_reload = 1'b1; low_only_reload = 1'b1;
      pause = 1'b1; pause_clears = 1'b0; put(8, 6); expect_out(1, 0, 0, "R9 no clear");
      edge_wait(); wr_valid = 1'b0; expect_out(1, 0, 0, "R8");
      repeat (4) begin edge_wait(); expect_out(1, 0, 0, "R8 guard"); end
      edge_wait(); expect_out(0, 0, 0, "R8 guard");
      run_period(8, 6, 0, 1'b0, 1'b1, "R8");

      // R8 without guard: restart while main is high
      edge_wait(); low_only_reload = 1'b0; put(2, 3); expect_out(1, 0, 0, "R8");
      edge_wait(); wr_valid = 1'b0; expect_out(1, 0, 0, "R8");
      run_period(2, 3, 0, 1'b0, 1'b1, "R8 restart");

      // R7: a gap as long as both phases keeps both outputs low
      pair_en = 1'b1; dead_ticks = DW'(3); fast_reload = 1'b0; pause = 1'b0;
      run_period(2, 3, 3, 1'b1, 1'b0, "R7");
      run_period(2, 3, 3, 1'b1, 1'b0, "R7");

      edge_wait();
      edge_wait();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule